// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller side of a circular command queue. Host software fills the queue and owns a write index. The block owns a read index and moves it forward. While the run bit is set and the two indices differ, the engine steps its read index forward by one slot, modulo the selected depth. It then reads the 32-bit command word stored at the new slot and presents it on a link-side output that uses a valid/ready handshake. Alongside the word, the engine drives the codec address taken from the top nibble of the command.

Software controls the block through a small register port with four registers:

| Address | Register | Contents |
|---|---|---|
| 0 | WP | Write index |
| 1 | RP | Read index and reset flag |
| 2 | CTL | Run bit |
| 3 | SIZE | Depth code |

The read index is cleared with a two-phase handshake: first set the reset flag, then write zero and confirm that zero reads back. A parameter selects a variant in which the flag clears itself. A ring-full output reports the state in which software must not post another command. The command words sit in a small internal memory that stands in for host memory. The testbench loads that memory through a load port.

A power-gate input makes the pointer registers read as all ones and halts fetching.

Top module: `cmd_ring_fetch_top`

## Requirements
- R1: After reset, reads return the following, and `cmd_valid` is 0:
  - WP (address 0) reads 0.
  - RP (address 1) reads 0.
  - CTL (address 2) reads 0.
  - SIZE (address 3) reads 2.
- R2: While the run bit is set, the reset flag is clear and RP differs from WP, the engine does the following:
  - It moves RP to (RP+1) mod depth.
  - It emits the word stored in that slot.
  - Words leave in slot order.
  - Once the queue drains, RP reads back equal to WP.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` and `cmd_data` stay unchanged. Each accepted transfer delivers exactly one queued word.
- R4: `cmd_codec` equals bits 31:28 of the word on `cmd_data`.
- R5: Writing RP with bit 15 set clears the read index to 0. While the flag stays set, RP reads back with bit 15 = 1 and no command is fetched.
- R6: Writing RP with bit 15 clear releases the flag. RP then reads 0 and fetching resumes. With SELF_CLEAR=1, the flag drops by itself one cycle after it is set.
- R7: Writing RP with bit 15 clear never changes the read index.
- R8: CTL bit 0 enables fetching.
  - After software clears the bit, CTL bit 0 still reads 1 while a fetched word has not yet been accepted.
  - It reads 0 once the engine is idle.
  - No new fetch starts while the bit is clear.
- R9: SIZE bits 1:0 select the depth: code 0 gives 2 slots, code 1 gives 16 slots, and code 2 or 3 gives 2^PTR_W slots (256 by default). Both indices wrap at the selected depth.
- R10: `ring_full` is 1 exactly when (WP+1) mod depth equals RP.
- R11: While `pwr_gate` is 1, WP and RP read 0xFFFF and no command is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_gate | input | 1 | Controller powered down |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 WP, 1 RP, 2 CTL, 3 SIZE) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data, one cycle after the address |
| host_we | input | 1 | Command memory load strobe |
| host_addr | input | PTR_W | Command memory load slot |
| host_data | input | CMD_W | Command memory load word |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Link side accepts the word |
| cmd_data | output | CMD_W | Command word |
| cmd_codec | output | 4 | Target codec address, bits 31:28 of the word |
| ring_full | output | 1 | Queue full, software must not post |

## Verification
The bench aims at the following corner cases:
- **Pointer wrap at a reduced depth.** An engine that masked with the wrong depth would emit stale slots or never drain.
- **Full condition with one slot kept empty.** An off-by-one here shows up as `ring_full` rising one post early or late.
- **Reset handshake.** A design that fetched while the flag was set, or failed to clear the flag on the zero write, would emit a word early or stall forever.
- **Stop with a word held on the link.** CTL reading 0 before that word leaves would let software tear down a queue that still has a command in flight.
- **Powered-down reads.** These must show all ones and fetch nothing.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  typedef enum logic [1:0] {
    RA_WP   = 2'd0,
    RA_RP   = 2'd1,
    RA_CTL  = 2'd2,
    RA_SIZE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_READ = 2'd1,
    FS_HOLD = 2'd2
  } fetch_state_e;

  localparam logic [1:0] SIZE_CODE_MAX = 2'd2;

  // Index mask for a depth code: 0 -> 2 slots, 1 -> 16 slots, else full depth
  function automatic logic [15:0] size_mask(input logic [1:0] code, input int unsigned pw);
    logic [15:0] m;
    case (code)
      2'd0:    m = 16'h0001;
      2'd1:    m = 16'h000F;
      default: m = 16'((32'd1 << pw) - 32'd1);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cmd_ring_mem.sv
module cmd_ring_mem #(
  parameter int PTR_W = 8,
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [CMD_W-1:0] wdata,
  input  logic             re,
  input  logic [PTR_W-1:0] raddr,
  output logic [CMD_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [CMD_W-1:0] store [DEPTH];

  // Simple dual-port array with a registered read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int REG_W      = 16,
  parameter bit SELF_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_gate,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             engine_busy,
  input  logic             rp_adv,
  output logic [PTR_W-1:0] wp_q,
  output logic [PTR_W-1:0] rp_q,
  output logic [PTR_W-1:0] idx_mask,
  output logic             run_req,
  output logic             rst_hold,
  output logic             ring_full
);
  localparam int RST_BIT = REG_W - 1;
  localparam int PAD_WP  = REG_W - PTR_W;
  localparam int PAD_RP  = REG_W - 1 - PTR_W;

  logic [1:0]       size_q;
  logic [15:0]      mask_full;
  logic             wr_wp, wr_rp, wr_ctl, wr_size;
  logic             rp_rst_set, rp_rst_rel;
  logic             auto_rel;
  logic [PTR_W-1:0] rp_next;
  logic [PTR_W-1:0] wp_next_slot;
  logic [REG_W-1:0] rd_mux;

  assign mask_full = size_mask(size_q, PTR_W);
  assign idx_mask  = mask_full[PTR_W-1:0];

  assign wr_wp   = reg_wr && (reg_addr == RA_WP);
  assign wr_rp   = reg_wr && (reg_addr == RA_RP);
  assign wr_ctl  = reg_wr && (reg_addr == RA_CTL);
  assign wr_size = reg_wr && (reg_addr == RA_SIZE);

  assign rp_rst_set = wr_rp &&  reg_wdata[RST_BIT];
  assign rp_rst_rel = wr_rp && !reg_wdata[RST_BIT];

  // Variant choice: the flag either waits for software or drops by itself
  generate
    if (SELF_CLEAR) begin : g_self_clear
      assign auto_rel = rst_hold;
    end else begin : g_sw_clear
      assign auto_rel = 1'b0;
    end
  endgenerate

  assign rp_next      = (rp_q + PTR_W'(1)) & idx_mask;
  assign wp_next_slot = (wp_q + PTR_W'(1)) & idx_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
    end else if (wr_wp) begin
      wp_q <= reg_wdata[PTR_W-1:0] & idx_mask;
    end
  end

  // Read index: hardware-owned, cleared only through the reset flag
  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q <= '0;
    end else if (rp_rst_set) begin
      rp_q <= '0;
    end else if (rp_adv) begin
      rp_q <= rp_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_hold <= 1'b0;
    end else if (rp_rst_set) begin
      rst_hold <= 1'b1;
    end else if (rp_rst_rel || auto_rel) begin
      rst_hold <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_req <= 1'b0;
      size_q  <= SIZE_CODE_MAX;
    end else begin
      if (wr_ctl)  run_req <= reg_wdata[0];
      if (wr_size) size_q  <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ring_full <= 1'b0;
    else     ring_full <= (wp_next_slot == rp_q);
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_WP:   rd_mux = pwr_gate ? '1 : {{PAD_WP{1'b0}}, wp_q};
      RA_RP:   rd_mux = pwr_gate ? '1 : {rst_hold, {PAD_RP{1'b0}}, rp_q};
      RA_CTL:  rd_mux = {{(REG_W-1){1'b0}}, run_req | engine_busy};
      default: rd_mux = {{(REG_W-2){1'b0}}, size_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R9: the index only steps by one within the selected depth, or returns to 0
  assert_rp_step_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rp_q) |-> (rp_q == '0) || (rp_q == (($past(rp_q) + PTR_W'(1)) & $past(idx_mask))));

  // R5: while the reset flag is held, the read index stays at zero
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rst_hold |-> (rp_q == '0));

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_req,
  input  logic             rst_hold,
  input  logic             pwr_gate,
  input  logic [PTR_W-1:0] wp_q,
  input  logic [PTR_W-1:0] rp_q,
  input  logic [PTR_W-1:0] idx_mask,
  output logic             rp_adv,
  output logic             mem_re,
  output logic [PTR_W-1:0] mem_raddr,
  input  logic [CMD_W-1:0] mem_rdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_data,
  output logic [3:0]       cmd_codec,
  output logic             busy
);
  fetch_state_e state_q, state_d;
  logic         can_fetch;

  assign can_fetch = run_req && !rst_hold && !pwr_gate && (rp_q != wp_q);
  assign mem_raddr = (rp_q + PTR_W'(1)) & idx_mask;
  assign busy      = (state_q != FS_IDLE);

  always_comb begin
    state_d = state_q;
    rp_adv  = 1'b0;
    mem_re  = 1'b0;
    case (state_q)
      FS_IDLE: if (can_fetch) begin
        rp_adv  = 1'b1;
        mem_re  = 1'b1;
        state_d = FS_READ;
      end
      FS_READ: state_d = FS_HOLD;
      FS_HOLD: if (cmd_ready) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= FS_IDLE;
    else     state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      cmd_codec <= '0;
    end else if (state_q == FS_READ) begin
      cmd_valid <= 1'b1;
      cmd_data  <= mem_rdata;
      cmd_codec <= mem_rdata[CMD_W-1 -: 4];
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R3: an offered word is held until the link accepts it
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data) && $stable(cmd_codec));

endmodule

// File: rtl/cmd_ring_fetch_top.sv
module cmd_ring_fetch_top
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int CMD_W      = 32,
  parameter int REG_W      = 16,
  parameter bit SELF_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_gate,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             host_we,
  input  logic [PTR_W-1:0] host_addr,
  input  logic [CMD_W-1:0] host_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_data,
  output logic [3:0]       cmd_codec,
  output logic             ring_full
);
  logic [PTR_W-1:0] wp_q, rp_q, idx_mask, mem_raddr;
  logic             run_req, rst_hold, rp_adv, mem_re, busy;
  logic [CMD_W-1:0] mem_rdata;

  cmd_ring_regs #(.PTR_W(PTR_W), .REG_W(REG_W), .SELF_CLEAR(SELF_CLEAR)) u_regs (
    .clk(clk), .rst(rst), .pwr_gate(pwr_gate),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .engine_busy(busy), .rp_adv(rp_adv),
    .wp_q(wp_q), .rp_q(rp_q), .idx_mask(idx_mask),
    .run_req(run_req), .rst_hold(rst_hold), .ring_full(ring_full)
  );

  cmd_ring_mem #(.PTR_W(PTR_W), .CMD_W(CMD_W)) u_mem (
    .clk(clk), .we(host_we), .waddr(host_addr), .wdata(host_data),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  cmd_ring_fetch #(.PTR_W(PTR_W), .CMD_W(CMD_W)) u_fetch (
    .clk(clk), .rst(rst), .run_req(run_req), .rst_hold(rst_hold), .pwr_gate(pwr_gate),
    .wp_q(wp_q), .rp_q(rp_q), .idx_mask(idx_mask),
    .rp_adv(rp_adv), .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_codec(cmd_codec), .busy(busy)
  );

  // R2: every index step is followed two cycles later by an offered word
  assert_fetch_emits_R2: assert property (@(posedge clk) disable iff (rst)
    rp_adv |=> ##1 cmd_valid);

  // R8: no step of the index happens while the run bit is clear
  assert_no_fetch_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    rp_adv |-> run_req && (wp_q != rp_q));

endmodule

// File: tb/cmd_ring_fetch_tb_top.sv
module cmd_ring_fetch_tb_top;
  localparam int PTR_W = 8;
  localparam int CMD_W = 32;
  localparam int REG_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pwr_gate = 1'b0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             host_we = 1'b0;
  logic [PTR_W-1:0] host_addr = '0;
  logic [CMD_W-1:0] host_data = '0;
  logic             cmd_valid;
  logic             cmd_ready = 1'b0;
  logic [CMD_W-1:0] cmd_data;
  logic [3:0]       cmd_codec;
  logic             ring_full;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int sw_wp = 0;
  int sw_mask = 255;
  logic [CMD_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  cmd_ring_fetch_top #(.PTR_W(PTR_W), .CMD_W(CMD_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .pwr_gate(pwr_gate),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_codec(cmd_codec), .ring_full(ring_full)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Link-side ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0:       cmd_ready <= 1'b1;
      1:       cmd_ready <= 1'($urandom_range(0, 1));
      default: cmd_ready <= 1'b0;
    endcase
  end

  // Monitor: pops the scoreboard on every accepted transfer (R2, R3, R4)
  always @(negedge clk) begin
    if (!rst && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected word", cmd_data, 32'h0);
      end else begin
        logic [CMD_W-1:0] e;
        e = exp_q.pop_front();
        check(cmd_data == e, "R2 word order", cmd_data, e);
        check(cmd_codec == e[31:28], "R4 codec field", 32'(cmd_codec), 32'(e[31:28]));
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [REG_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [REG_W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // Driver: loads the next slot, records the expected word, publishes WP
  task automatic post(input logic [CMD_W-1:0] w);
    int slot;
    slot = (sw_wp + 1) & sw_mask;
    @(negedge clk);
    host_we = 1'b1; host_addr = PTR_W'(slot); host_data = w;
    @(negedge clk);
    host_we = 1'b0;
    exp_q.push_back(w);
    sw_wp = slot;
    reg_write(2'd0, REG_W'(slot));
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
  endtask

  task automatic ptr_restart();
    reg_write(2'd1, 16'h8000);
    reg_write(2'd1, 16'h0000);
    reg_write(2'd0, 16'h0000);
    sw_wp = 0;
  endtask

  initial begin
    logic [REG_W-1:0] rd;
    logic [CMD_W-1:0] held;
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [REG_W-1:0] rd;
    logic [CMD_W-1:0] held;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // R1 reset state
    reg_read(2'd0, rd); check(rd == 16'h0, "R1 WP reset", 32'(rd), 32'h0);
    reg_read(2'd1, rd); check(rd == 16'h0, "R1 RP reset", 32'(rd), 32'h0);
    reg_read(2'd2, rd); check(rd == 16'h0, "R1 CTL reset", 32'(rd), 32'h0);
    reg_read(2'd3, rd); check(rd == 16'h2, "R1 SIZE reset", 32'(rd), 32'h2);
    check(cmd_valid == 1'b0, "R1 valid reset", 32'(cmd_valid), 32'h0);

    // R5 reset phase one blocks fetching
    reg_write(2'd1, 16'h8000);
    reg_read(2'd1, rd); check(rd == 16'h8000, "R5 reset flag readback", 32'(rd), 32'h8000);
    reg_write(2'd2, 16'h1);
    post(32'hA000_0001);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 1, "R5 no fetch while flag set", 32'(exp_q.size()), 32'h1);
    // R6 phase two releases
    reg_write(2'd1, 16'h0000);
    reg_read(2'd1, rd);
    check(rd == 16'h0000 || rd == 16'h0001, "R6 flag released", 32'(rd), 32'h0);
    drain("R6 fetch resumes");

    // R2 several words with irregular ready
    ready_mode = 1;
    for (int i = 0; i < 12; i++) post({4'(i), 28'($urandom)});
    drain("R2 drain random ready");
    reg_read(2'd1, rd); check(rd == 16'(sw_wp), "R2 RP equals WP", 32'(rd), 32'(sw_wp));

    // R7 RP write without reset bit leaves index alone
    reg_write(2'd1, 16'h0005);
    reg_read(2'd1, rd); check(rd == 16'(sw_wp), "R7 RP unchanged", 32'(rd), 32'(sw_wp));

    // R3 stall and R8 stop with a word held
    ready_mode = 2;
    repeat (3) @(negedge clk);
    post(32'h5123_4567);
    repeat (6) @(negedge clk);
    held = cmd_data;
    check(cmd_valid == 1'b1, "R3 valid while stalled", 32'(cmd_valid), 32'h1);
    repeat (4) @(negedge clk);
    check(cmd_valid == 1'b1 && cmd_data == held, "R3 data stable", cmd_data, held);
    reg_write(2'd2, 16'h0);
    reg_read(2'd2, rd); check(rd == 16'h1, "R8 busy reads 1", 32'(rd), 32'h1);
    ready_mode = 0;
    drain("R3 stalled word delivered");
    repeat (4) @(negedge clk);
    reg_read(2'd2, rd); check(rd == 16'h0, "R8 stopped reads 0", 32'(rd), 32'h0);
    post(32'h7777_0000);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 1, "R8 no fetch when stopped", 32'(exp_q.size()), 32'h1);
    reg_write(2'd2, 16'h1);
    drain("R8 restart");
    reg_write(2'd2, 16'h0);
    repeat (6) @(negedge clk);

    // R9 depth 16 and R10 full
    ptr_restart();
    reg_write(2'd3, 16'h1);
    sw_mask = 15;
    for (int i = 0; i < 14; i++) post({4'(i + 2), 28'(i * 3)});
    repeat (3) @(negedge clk);
    check(ring_full == 1'b0, "R10 not full at 14", 32'(ring_full), 32'h0);
    post(32'hF000_000F);
    repeat (3) @(negedge clk);
    check(ring_full == 1'b1, "R10 full at 15", 32'(ring_full), 32'h1);
    ready_mode = 1;
    reg_write(2'd2, 16'h1);
    drain("R9 drain depth 16");
    reg_read(2'd1, rd); check(rd == 16'd15, "R9 RP at top slot", 32'(rd), 32'd15);
    for (int i = 0; i < 3; i++) post({4'(9 - i), 28'(i)});
    drain("R9 wrap drain");
    reg_read(2'd1, rd); check(rd == 16'd2, "R9 RP wrapped", 32'(rd), 32'd2);

    // R9 depth 2
    reg_write(2'd2, 16'h0);
    repeat (6) @(negedge clk);
    ptr_restart();
    reg_write(2'd3, 16'h0);
    sw_mask = 1;
    reg_write(2'd2, 16'h1);
    post(32'h1111_1111);
    drain("R9 depth 2 first");
    post(32'h2222_2222);
    drain("R9 depth 2 second");
    reg_read(2'd1, rd); check(rd == 16'd0, "R9 RP wrapped at 2", 32'(rd), 32'd0);

    // R11 power gate
    pwr_gate = 1'b1;
    reg_read(2'd0, rd); check(rd == 16'hFFFF, "R11 WP gated", 32'(rd), 32'hFFFF);
    reg_read(2'd1, rd); check(rd == 16'hFFFF, "R11 RP gated", 32'(rd), 32'hFFFF);
    post(32'h3333_3333);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 1, "R11 no fetch gated", 32'(exp_q.size()), 32'h1);
    pwr_gate = 1'b0;
    drain("R11 resume after gate");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule